// File: doc/BRIEF.md
# Reset Mode Latch with Instruction-Start Strobe

This block sets a processor's operating mode from two board-level select pins. While the chip reset is held, it watches both pins through a synchroniser. On the first clock edge after reset goes away, it decodes the pin pair once into a two-bit mode code and four control bits. From then on the mode is frozen, whatever the pins do.

After reset, one of the two pins is reused as an instruction-start marker for a logic analyser. The core raises a one-cycle opcode-fetch pulse. For each such pulse, the block asserts a pull-low enable for the shared pin during the following cycle. The pin is open-drain: the block can only pull it low or leave it released, so a pin tied straight to ground never contends with it. The second select pin has no output role.

Top module: `mode_strobe_top`

## Requirements
- R1: While `rst_n` is low, at every clock edge all four control bits, `mode_code` and `strobe_pull_low` go to 0, whatever `fetch_start` and the pins do.
- R2: On the first clock edge with `rst_n` high after reset, `mode_code` takes the value decoded from the pin pair (b,a): (1,0) gives 0 (single-chip), (1,1) gives 1 (expanded), (0,0) gives 2 (bootstrap) and (0,1) gives 3 (test).
- R3: On that same edge the control bits {rom_boot, special_mode, expanded_mode, vector_select} are set as follows: 0000 for single-chip, 0010 for expanded, 1101 for bootstrap and 0111 for test.
- R4: With the default two synchroniser stages, the pin levels that count are the ones present at the third-from-last clock edge of reset. A pin change first seen at the final reset edge is not used.
- R5: Once reset has been released, pin changes never alter `mode_code` or the control bits until the next reset.
- R6: Outside reset, `strobe_pull_low` is 1 in exactly the cycles that follow a cycle with `fetch_start` high. Back-to-back fetch pulses therefore give consecutive low cycles, and the number of strobe cycles equals the number of fetch pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; mode pins are watched while it is low |
| mode_pin_b | input | 1 | Mode select pin B, input only |
| mode_pin_a | input | 1 | Mode select pin A, also the shared strobe pin |
| fetch_start | input | 1 | One-cycle pulse from the core at each opcode fetch |
| rom_boot | output | 1 | Latched boot-from-ROM control bit |
| special_mode | output | 1 | Latched special-mode control bit |
| expanded_mode | output | 1 | Latched expanded-bus control bit |
| vector_select | output | 1 | Latched alternate-vector control bit |
| mode_code | output | 2 | Latched mode: 0 single-chip, 1 expanded, 2 bootstrap, 3 test |
| strobe_pull_low | output | 1 | Open-drain enable: 1 pulls the shared pin low, 0 releases it |

## Verification
A wrong pin-hold or lock state shows on the first output edge after reset. In that case `mode_code` and the control bits disagree with the pin combination from three edges before release. If the lock is lost later, the outputs move with the pins in the cycle after a pin toggle passes the synchroniser. A bad strobe register shows within one cycle as a low cycle with no fetch, or a missing one. Over a run of pulses, the strobe count then no longer matches the fetch count.

// File: rtl/mode_strobe_pkg.sv
// Shared types and decode functions for the reset mode latch.
// Assumes the pin pair is given as {b, a}.
package mode_strobe_pkg;

    typedef enum logic [1:0] {
        MC_SINGLE = 2'd0,
        MC_EXPAND = 2'd1,
        MC_BOOT   = 2'd2,
        MC_TEST   = 2'd3
    } mode_code_e;

    typedef struct packed {
        logic rom_boot;
        logic special;
        logic expanded;
        logic vec_sel;
    } mode_ctrl_t;

    // Map the sampled pin pair {b, a} to a mode code.
    function automatic mode_code_e pins_to_code(input logic [1:0] ba);
        case (ba)
            2'b10:   return MC_SINGLE;
            2'b11:   return MC_EXPAND;
            2'b00:   return MC_BOOT;
            default: return MC_TEST;
        endcase
    endfunction

    // Map a mode code to its four control bits.
    function automatic mode_ctrl_t code_to_ctrl(input mode_code_e code);
        case (code)
            MC_SINGLE: return '{rom_boot: 1'b0, special: 1'b0, expanded: 1'b0, vec_sel: 1'b0};
            MC_EXPAND: return '{rom_boot: 1'b0, special: 1'b0, expanded: 1'b1, vec_sel: 1'b0};
            MC_BOOT:   return '{rom_boot: 1'b1, special: 1'b1, expanded: 1'b0, vec_sel: 1'b1};
            default:   return '{rom_boot: 1'b0, special: 1'b1, expanded: 1'b1, vec_sel: 1'b1};
        endcase
    endfunction

endpackage

// File: rtl/mode_pin_sync.sv
// Multi-stage synchroniser for asynchronous board pins.
// It has no reset on purpose: it must run while the chip reset is held,
// because that is the only time its output is used.
module mode_pin_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];

    // First stage: capture the raw pin levels.
    always_ff @(posedge clk) begin
        chain[0] <= din;
    end

    // Later stages: shift the chain along.
    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign dout = chain[LAST];
endmodule

// File: rtl/mode_capture.sv
// Holds the synchronised pin pair at every reset edge. At the first edge
// after reset it decodes the held pair once and locks the result.
// Assumes rst_n is synchronous and active low.
module mode_capture
    import mode_strobe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pins_sync,
    output mode_code_e code,
    output mode_ctrl_t ctrl
);
    logic [1:0] pin_hold;
    logic       locked;
    mode_code_e code_q;
    mode_ctrl_t ctrl_q;

    // Track the synchronised pins only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_hold <= pins_sync;
    end

    // Decode once on the first edge out of reset, then keep the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
            code_q <= MC_SINGLE;
            ctrl_q <= '0;
        end else if (!locked) begin
            locked <= 1'b1;
            code_q <= pins_to_code(pin_hold);
            ctrl_q <= code_to_ctrl(pins_to_code(pin_hold));
        end
    end

    assign code = code_q;
    assign ctrl = ctrl_q;
endmodule

// File: rtl/fetch_strobe.sv
// Turns the core's one-cycle fetch pulse into a pull-low enable for the
// shared open-drain pin, one cycle later. It is held released during reset.
module fetch_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic fetch_start,
    output logic pull_low
);
    logic pull_q;

    // Register the fetch pulse; reset forces the pin released.
    always_ff @(posedge clk) begin
        if (!rst_n) pull_q <= 1'b0;
        else        pull_q <= fetch_start;
    end

    assign pull_low = pull_q;
endmodule

// File: rtl/mode_strobe_top.sv
// Top of the reset mode latch. It synchronises the two select pins,
// latches the mode at reset release and drives the open-drain strobe enable.
// The pin-A pad drives only low, under strobe_pull_low. Pin B is input only.
module mode_strobe_top #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_pin_b,
    input  logic       mode_pin_a,
    input  logic       fetch_start,
    output logic       rom_boot,
    output logic       special_mode,
    output logic       expanded_mode,
    output logic       vector_select,
    output logic [1:0] mode_code,
    output logic       strobe_pull_low
);
    import mode_strobe_pkg::*;

    localparam int PIN_W = 2;

    logic [PIN_W-1:0] pins_sync;
    mode_code_e       code;
    mode_ctrl_t       ctrl;

    mode_pin_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .din  ({mode_pin_b, mode_pin_a}),
        .dout (pins_sync)
    );

    mode_capture cap_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins_sync (pins_sync),
        .code      (code),
        .ctrl      (ctrl)
    );

    fetch_strobe strb_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_start (fetch_start),
        .pull_low    (strobe_pull_low)
    );

    assign mode_code     = code;
    assign rom_boot      = ctrl.rom_boot;
    assign special_mode  = ctrl.special;
    assign expanded_mode = ctrl.expanded;
    assign vector_select = ctrl.vec_sel;
endmodule

// File: rtl/mode_strobe_chk.sv
// Assertion checker for mode_strobe_top, attached through bind.
module mode_strobe_chk
    import mode_strobe_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       fetch_start,
    input logic       rom_boot,
    input logic       special_mode,
    input logic       expanded_mode,
    input logic       vector_select,
    input logic [1:0] mode_code,
    input logic       strobe_pull_low
);
    logic [1:0] up_cnt;
    logic [3:0] bits;

    assign bits = {rom_boot, special_mode, expanded_mode, vector_select};

    // Count cycles since reset release, saturating at 2.
    always_ff @(posedge clk) begin
        if (!rst_n)            up_cnt <= 2'd0;
        else if (up_cnt != 2'd2) up_cnt <= up_cnt + 2'd1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!strobe_pull_low && mode_code == 2'd0 && bits == 4'd0));

    assert_bits_match_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt != 2'd0) |-> (bits == code_to_ctrl(mode_code_e'(mode_code))));

    assert_mode_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt == 2'd2) |-> ($stable(mode_code) && $stable(bits)));

    assert_strobe_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_start |=> strobe_pull_low);

    assert_strobe_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_start |=> !strobe_pull_low);
endmodule

bind mode_strobe_top mode_strobe_chk chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .fetch_start     (fetch_start),
    .rom_boot        (rom_boot),
    .special_mode    (special_mode),
    .expanded_mode   (expanded_mode),
    .vector_select   (vector_select),
    .mode_code       (mode_code),
    .strobe_pull_low (strobe_pull_low)
);

// File: tb/mode_strobe_top_tb_top.sv
module mode_strobe_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_b = 1'b0;
    logic       pin_a = 1'b0;
    logic       fetch = 1'b0;
    logic       rom_boot, special_mode, expanded_mode, vector_select, strobe;
    logic [1:0] mode_code;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mode_strobe_top dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .mode_pin_b      (pin_b),
        .mode_pin_a      (pin_a),
        .fetch_start     (fetch),
        .rom_boot        (rom_boot),
        .special_mode    (special_mode),
        .expanded_mode   (expanded_mode),
        .vector_select   (vector_select),
        .mode_code       (mode_code),
        .strobe_pull_low (strobe)
    );

    // Expected mode code for pins {b, a}.
    function automatic logic [1:0] exp_code(input logic b, input logic a);
        case ({b, a})
            2'b10:   return 2'd0;
            2'b11:   return 2'd1;
            2'b00:   return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    // Expected {rom_boot, special, expanded, vector_select} for a mode code.
    function automatic logic [3:0] exp_bits(input logic [1:0] c);
        case (c)
            2'd0:    return 4'b0000;
            2'd1:    return 4'b0010;
            2'd2:    return 4'b1101;
            default: return 4'b0111;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] outs();
        return {mode_code, rom_boot, special_mode, expanded_mode, vector_select};
    endfunction

    // Hold reset for some cycles with the given pins, then release it and
    // check the latched mode. The last fetch value is 0 at release.
    task automatic reset_with(input logic b, input logic a, input int cyc);
        logic [5:0] e;
        @(negedge clk);
        rst_n = 1'b0; pin_b = b; pin_a = a;
        for (int i = 0; i < cyc; i++) begin
            fetch = 1'($urandom);
            @(negedge clk);
            check(outs() == 6'd0 && strobe == 1'b0, "R1", {outs(), strobe}, 0);
        end
        fetch = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        e = {exp_code(b, a), exp_bits(exp_code(b, a))};
        check(mode_code == e[5:4], "R2", mode_code, e[5:4]);
        check(outs() == e, "R3", outs(), e);
    endtask

    // Run with random pins and fetch pulses; check the strobe and the frozen mode.
    task automatic run_phase(input int n);
        logic [5:0] snap;
        logic       prev;
        int         pulses;
        int         lows;
        snap = outs(); prev = 1'b0; pulses = 0; lows = 0;
        for (int i = 0; i < n; i++) begin
            check(strobe == prev, "R6", strobe, prev);
            check(outs() == snap, "R5", outs(), snap);
            if (strobe) lows++;
            pin_b = 1'($urandom); pin_a = 1'($urandom);
            fetch = (i < 3) ? 1'b1 : ((i % 3 == 0) ? 1'b1 : 1'($urandom));
            if (fetch) pulses++;
            prev = fetch;
            @(negedge clk);
        end
        fetch = 1'b0;
        if (strobe) lows++;
        check(strobe == prev, "R6", strobe, prev);
        @(negedge clk);
        check(lows == pulses, "R6 count", lows, pulses);
        check(outs() == snap, "R5", outs(), snap);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        // Directed sweep of all four pin combinations.
        for (int k = 0; k < 4; k++) begin
            reset_with(1'(k >> 1), 1'(k), 6);
            run_phase(30);
        end
        // R4: a change seen only at the final reset edge is ignored.
        reset_with(1'b1, 1'b0, 6);
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk); @(negedge clk); @(negedge clk);
        pin_b = 1'b0; pin_a = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(mode_code == 2'd0, "R4 late", mode_code, 0);
        // R4: a change present at the third-from-last reset edge is used.
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        pin_b = 1'b0; pin_a = 1'b1;
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(mode_code == 2'd3, "R4 early", mode_code, 3);
        check(outs() == {2'd3, 4'b0111}, "R4 bits", outs(), {2'd3, 4'b0111});
        // Random pin combinations.
        for (int k = 0; k < 10; k++) begin
            reset_with(1'($urandom), 1'($urandom), 4 + int'($urandom % 4));
            run_phase(20 + int'($urandom % 20));
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule